// File: doc/BRIEF.md
# Segment-Scan Seven-Segment Display Driver

This block lights a row of common-line seven-segment digits by walking through the segments rather than through the digits. In each time slot exactly one segment line is selected. Every digit whose pattern contains that segment has its common line driven active for the length of the slot. Each segment gets its slot in every scan, whatever characters are on show. A scan is seven slots long, or eight when the decimal point is included.

The segment lines are not driven in parallel. They come from an external two-wire fan-out part, and the block drives that part in one of two ways. In shift mode it drives a plain serial-in, parallel-out shift register with no output latch, using a data line and a clock. In counter mode it drives a decoded one-hot counter, using a clock and an active-high reset. The slot rate comes from an external tick strobe. The block blanks all digit lines while the fan-out part moves, so a slot never shows a neighbouring segment's column.

Top module: `seg_scan_top`

## Requirements
- R1: While reset is high, every digit line, selClk, selRst and selData are low.
- R2: A scan visits fan-out positions 0, 1, 2 and onwards in order. It has 7 slots when the decimal point is off and 8 when it is on. During slot s, output s of the fan-out part is the only one of its first eight outputs that is high. In counter mode positions 8 and 9 also stay low.
- R3: During slot s, digit line k is high exactly when bit s of digit k's byte is 1. That bit is digitPat[8k+s], where bits 0 to 6 are segments a to g and bit 7 is the decimal point.
- R4: In shift mode the fan-out is driven only by selData and selClk, and selRst stays low. After reset, or on re-entry from counter mode, a scan starts with eight clocks at data 0 and then one clock at data 1. Any later scan start pushes the previous 1 past output 7, and its final clock carries data 1.
- R5: In counter mode, each advance within a scan is one selClk pulse. Every scan start is one selRst pulse instead, which leaves position 0 high. selData is low while selRst is high, and each selRst or selClk pulse lasts one cycle.
- R6: modeCounter (1 = counter mode) and dpEnable are sampled only when a new scan starts. A change made in mid-scan takes effect at the next scan.
- R7: The slot advances only on a tick seen while a slot is on show. Without a tick the display holds. A tick that arrives while a transition is in progress is ignored.
- R8: Every digit line is low in any cycle in which selClk or selRst is high, and from the tick until the new slot's column is shown.
- R9: The column shown in a slot is taken from digitPat at the slot boundary. A pattern change within a slot does not alter the digit lines until the next slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Slot-rate strobe, one cycle wide |
| modeCounter | input | 1 | 1 selects counter fan-out, 0 selects shift-register fan-out |
| dpEnable | input | 1 | 1 adds the decimal-point slot to the scan |
| digitPat | input | 8*NUM_DIGITS | Segment byte per digit, digit k at bits 8k+7 down to 8k |
| digitOn | output | NUM_DIGITS | Digit common lines, high means the digit is driven |
| selData | output | 1 | Serial data to the shift-register fan-out |
| selClk | output | 1 | Clock pulse to the fan-out part |
| selRst | output | 1 | Active-high reset pulse to the counter fan-out |

## Verification
The bench models both fan-out parts, each starting from a scrambled power-on state, and compares their outputs and the digit lines with a scoreboard after every slot. It forces both mode switches and a 7/8-slot change in mid-scan, so a design that sampled those inputs at any time other than the scan start would select the wrong segment. A design that dropped the power-up clear, or that failed to flush the leftover 1 at a 7-slot wrap, would leave two outputs high at once. The bench also fires a second tick during a transition and holds the display with no tick, which catches a double advance or a free-running scan. It changes a pattern in mid-slot, which catches columns that are not latched at the boundary. A separate count records any cycle in which the digit lines are lit while the fan-out part is being clocked or reset.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  localparam int SEG_BITS     = 8;
  localparam int SLOT_W       = $clog2(SEG_BITS);
  localparam int CLEAR_PULSES = SEG_BITS + 1;
  localparam int PULSE_W      = $clog2(CLEAR_PULSES + 1);

  typedef enum logic [1:0] {
    ST_SHOW   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } scanState_e;

  typedef struct packed {
    logic              clkHi;
    logic              rstHi;
    logic              dataBit;
    logic              loadCol;
    logic              show;
    logic [SLOT_W-1:0] slot;
  } scanStrobe_t;
endpackage

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl
  import seg_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        modeCounter,
  input  logic        dpEnable,
  output scanStrobe_t strobes
);
  scanState_e         state;
  logic [SLOT_W-1:0]  slot;
  logic [SLOT_W-1:0]  lastSlot;
  logic [PULSE_W-1:0] pulsesLeft;
  logic               modeCnt;
  logic               pulseIsRst;
  logic               needClear;
  logic               kick;
  logic               step;
  logic               cycleStart;
  logic               inBurst;
  logic               lastPulse;

  assign step       = (state == ST_SHOW) && (kick || tick);
  assign cycleStart = (slot == lastSlot);
  assign inBurst    = (state == ST_SETUP) || (state == ST_STROBE);
  assign lastPulse  = (pulsesLeft == PULSE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SHOW;
      slot       <= SLOT_W'(SEG_BITS - 1);
      lastSlot   <= SLOT_W'(SEG_BITS - 1);
      pulsesLeft <= PULSE_W'(1);
      modeCnt    <= 1'b0;
      pulseIsRst <= 1'b0;
      needClear  <= 1'b1;
      kick       <= 1'b1;
    end else begin
      unique case (state)
        ST_SHOW: begin
          if (step) begin
            kick  <= 1'b0;
            state <= ST_SETUP;
            if (cycleStart) begin
              slot     <= '0;
              modeCnt  <= modeCounter;
              lastSlot <= dpEnable ? SLOT_W'(SEG_BITS - 1) : SLOT_W'(SEG_BITS - 2);
              if (modeCounter) begin
                pulsesLeft <= PULSE_W'(1);
                pulseIsRst <= 1'b1;
                needClear  <= 1'b1;
              end else begin
                pulsesLeft <= needClear ? PULSE_W'(CLEAR_PULSES)
                                        : PULSE_W'(SEG_BITS) - PULSE_W'(lastSlot);
                pulseIsRst <= 1'b0;
                needClear  <= 1'b0;
              end
            end else begin
              slot       <= slot + SLOT_W'(1);
              pulsesLeft <= PULSE_W'(1);
              pulseIsRst <= 1'b0;
            end
          end
        end
        ST_SETUP: state <= ST_STROBE;
        ST_STROBE: begin
          if (lastPulse) begin
            state <= ST_SHOW;
          end else begin
            pulsesLeft <= pulsesLeft - PULSE_W'(1);
            state      <= ST_SETUP;
          end
        end
        default: state <= ST_SHOW;
      endcase
    end
  end

  always_comb begin
    strobes.clkHi   = (state == ST_STROBE) && !pulseIsRst;
    strobes.rstHi   = (state == ST_STROBE) && pulseIsRst;
    strobes.dataBit = inBurst && !modeCnt && !pulseIsRst && lastPulse && (slot == '0);
    strobes.loadCol = (state == ST_STROBE) && lastPulse;
    strobes.show    = (state == ST_SHOW) && !step;
    strobes.slot    = slot;
  end

  // R2: the slot index never runs past the last slot of the scan
  p_slot_bound_r2: assert property (@(posedge clk) disable iff (rst)
    slot <= lastSlot);

  // R7: with no tick and no pending start the displayed slot holds
  p_tick_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHOW && !kick && !tick) |=> (state == ST_SHOW && $stable(slot)));
endmodule

// File: rtl/seg_scan_datapath.sv
module seg_scan_datapath
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  scanStrobe_t                  strobes,
  input  logic [NUM_DIGITS*SEG_BITS-1:0] digitPat,
  output logic [NUM_DIGITS-1:0]        digitOn,
  output logic                         selData,
  output logic                         selClk,
  output logic                         selRst
);
  logic [NUM_DIGITS-1:0] colNext;
  logic [NUM_DIGITS-1:0] colReg;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_col
    assign colNext[k] = digitPat[k*SEG_BITS + int'(strobes.slot)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      selClk  <= 1'b0;
      selRst  <= 1'b0;
      selData <= 1'b0;
      colReg  <= '0;
      digitOn <= '0;
    end else begin
      selClk  <= strobes.clkHi;
      selRst  <= strobes.rstHi;
      selData <= strobes.dataBit;
      if (strobes.loadCol) colReg <= colNext;
      digitOn <= strobes.show ? colReg : '0;
    end
  end

  // R8: digit lines dark whenever the fan-out part is being moved
  p_blank_r8: assert property (@(posedge clk) disable iff (rst)
    (selClk || selRst) |-> (digitOn == '0));
endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           tick,
  input  logic                           modeCounter,
  input  logic                           dpEnable,
  input  logic [NUM_DIGITS*SEG_BITS-1:0] digitPat,
  output logic [NUM_DIGITS-1:0]          digitOn,
  output logic                           selData,
  output logic                           selClk,
  output logic                           selRst
);
  scanStrobe_t strobes;

  seg_scan_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .modeCounter (modeCounter),
    .dpEnable    (dpEnable),
    .strobes     (strobes)
  );

  seg_scan_datapath #(.NUM_DIGITS(NUM_DIGITS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .digitPat (digitPat),
    .digitOn  (digitOn),
    .selData  (selData),
    .selClk   (selClk),
    .selRst   (selRst)
  );

  // R5: counter reset carries no data and is a single-cycle pulse
  p_rst_nodata_r5: assert property (@(posedge clk) disable iff (rst)
    selRst |-> !selData);
  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    selRst |=> !selRst);
  // R4: each fan-out clock is a single-cycle pulse with a low gap after it
  p_clk_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    selClk |=> !selClk);
endmodule

// File: tb/sim_seg_scan_top.sv
module sim_seg_scan_top;
  localparam int ND = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          modeCounter = 1'b0;
  logic          dpEnable = 1'b0;
  logic [ND*8-1:0] digitPat = '0;
  logic [ND-1:0] digitOn;
  logic          selData;
  logic          selClk;
  logic          selRst;

  int checks = 0;
  int failures = 0;
  int blankErr = 0;

  logic [7:0] srModel  = 8'hA5;
  logic [9:0] cntModel = 10'b0000100100;

  int         expSlot = 0;
  int         expLast = 6;
  logic       expMode = 1'b0;
  logic [ND-1:0] expCol = '0;

  typedef struct {
    logic          useCnt;
    logic [9:0]    seg;
    logic [ND-1:0] dig;
    string         tag;
  } item_t;
  item_t sbq[$];
  event  sampleEv;

  always #5 clk = ~clk;

  seg_scan_top #(.NUM_DIGITS(ND)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .modeCounter(modeCounter),
    .dpEnable(dpEnable), .digitPat(digitPat), .digitOn(digitOn),
    .selData(selData), .selClk(selClk), .selRst(selRst)
  );

  // external fan-out part models and the blanking monitor (R8)
  always @(negedge clk) begin
    if (!rst) begin
      if (selRst) cntModel <= 10'b1;
      else if (selClk) cntModel <= {cntModel[8:0], cntModel[9]};
      if (selClk) srModel <= {srModel[6:0], selData};
      if ((selClk || selRst) && digitOn != '0) blankErr++;
    end
  end

  function automatic logic [ND-1:0] colOf(input logic [ND*8-1:0] p, input int s);
    logic [ND-1:0] c;
    for (int k = 0; k < ND; k++) c[k] = p[k*8 + s];
    return c;
  endfunction

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expectNow(input string tag);
    item_t it;
    it.useCnt = expMode;
    it.seg    = 10'b1 << expSlot;
    it.dig    = expCol;
    it.tag    = tag;
    sbq.push_back(it);
    ->sampleEv;
    #1;
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(sampleEv);
      while (sbq.size() > 0) begin
        item_t it;
        logic [9:0] actSeg;
        it = sbq.pop_front();
        actSeg = it.useCnt ? cntModel : {2'b00, srModel};
        checks++;
        if (actSeg !== it.seg || digitOn !== it.dig) begin
          failures++;
          $display("FAIL %s seg act=%b exp=%b dig act=%b exp=%b",
                   it.tag, actSeg, it.seg, digitOn, it.dig);
        end
      end
    end
  end

  task automatic pulseTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic advanceExp();
    if (expSlot == expLast) begin
      expSlot = 0;
      expMode = modeCounter;
      expLast = dpEnable ? 7 : 6;
    end else begin
      expSlot++;
    end
    expCol = colOf(digitPat, expSlot);
  endtask

  task automatic stepSlot(input string tag);
    pulseTick();
    advanceExp();
    repeat (24) @(negedge clk);
    expectNow(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    digitPat = {8'hFF, 8'h5B, 8'h06, 8'hBF};
    repeat (5) @(negedge clk);
    // R1: quiet outputs under reset
    checkVal("R1 digitOn", 32'(digitOn), 32'h0);
    checkVal("R1 sel lines", {29'b0, selClk, selRst, selData}, 32'h0);
    rst = 1'b0;
    expSlot = 0; expMode = 1'b0; expLast = 6;
    expCol = colOf(digitPat, 0);
    repeat (24) @(negedge clk);
    expectNow("R4 power-up clear then single one, slot 0");

    // R2 R3: full 7-slot scan and wrap, shift mode
    for (int i = 0; i < 8; i++) stepSlot("R2 R3 shift 7-slot scan");

    // R7: second tick during the transition is ignored
    pulseTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    advanceExp();
    repeat (24) @(negedge clk);
    expectNow("R7 tick during transition ignored");
    // R7: no tick, display holds
    repeat (40) @(negedge clk);
    expectNow("R7 hold without tick");

    // R9: mid-slot pattern change keeps current column
    digitPat = {8'h00, 8'hA4, 8'h7F, 8'h12};
    repeat (3) @(negedge clk);
    expectNow("R9 mid-slot change not shown");
    stepSlot("R9 new pattern at next boundary");

    // R6: dpEnable raised in mid-scan, current scan stays 7 slots
    dpEnable = 1'b1;
    while (expSlot != 0) stepSlot("R6 dp change deferred");
    for (int i = 0; i < 8; i++) stepSlot("R2 R3 shift 8-slot scan incl decimal point");

    // R6: counter mode selected in mid-scan, applies at next scan
    stepSlot("R6 mode change deferred");
    modeCounter = 1'b1;
    stepSlot("R6 still shift mode");
    while (expSlot != 0) stepSlot("R6 shift until wrap");
    // R5: counter scans, 8 then 7 slots
    for (int i = 0; i < 8; i++) stepSlot("R5 counter 8-slot scan");
    dpEnable = 1'b0;
    digitPat = {8'h3F, 8'h66, 8'hE7, 8'h80};
    for (int i = 0; i < 9; i++) stepSlot("R5 counter 7-slot scan and reset wrap");

    // R4: back to shift mode, clear flush from counter leftovers
    modeCounter = 1'b0;
    while (expSlot != 0) stepSlot("R4 counter until wrap");
    for (int i = 0; i < 3; i++) stepSlot("R4 shift after re-entry clear");

    // R8: blanking aggregate
    checkVal("R8 lit while fan-out moving", 32'(blankErr), 32'h0);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule